// File: doc/BRIEF.md
# Single-Cycle Nibble Register CPU

This block is a small processor core that finishes one 16-bit instruction in every clock cycle. It contains a program counter, an opcode decoder, eight 4-bit general registers, a four-function ALU whose adder also subtracts, and a write-back selector. The core drives an instruction address on `progAddr` and reads the instruction word back on `progInstr` in the same cycle. The program store sits outside the core. Whatever instantiates the core fills that store and returns its words without delay.

The decoder turns the 4-bit opcode into a 7-bit control word. The word holds a subtract flag, a 2-bit ALU selector, a 2-bit write-back selector, a display enable and a register write enable. The datapath reads two source registers through combinational ports. It writes at most one destination register on the rising clock edge. The display instruction writes no register. Instead it raises a strobe for one cycle and presents both of its source registers on two output nibbles. The second nibble is the value to be shown. There are no branches, flags or data memory.

Top module: `nibble_cpu`

## Requirements
- R1: The instruction word is split into fields at fixed positions. The opcode is bits [15:12], the destination register is [10:8], source A is [6:4] and source B is [2:0]. The immediate of a load is the full 4-bit field [3:0], so bit 3 is part of the immediate value.
- R2: Opcode 0001 (load) writes the 4-bit immediate into the destination register.
- R3: Opcode 0010 (move) copies the value of source A into the destination register.
- R4: Opcodes 0100, 0101 and 0110 write the bitwise XOR, AND and OR of source A and source B into the destination register.
- R5: Opcode 0111 writes the sum of source A and source B, modulo 16.
- R6: Opcode 1111 writes source A minus source B, formed as A + ~B + 1 modulo 16.
- R7: Opcode 0011 (display) drives `dispStrobe` high for that cycle only. It presents source A on `dispA` and source B on `dispB`, and it changes no register. In every other cycle `dispStrobe` is low.
- R8: Opcode 0000 and the unused opcodes 1000 through 1110 change no register and raise no strobe.
- R9: `progAddr` advances by one each cycle after reset and wraps from 255 to 0.
- R10: A synchronous active-high `rst` clears the program counter and all eight registers to zero.
- R11: A register write takes effect at the clock edge that ends the instruction. An instruction that reads its own destination register sees the old value.
- R12: The program 0x1000, 0x1101, 0x1203, 0x1303, 0x3023, 0x2420, 0xF441, 0x3024, 0x7331, 0x3023, 0x4534, 0x3025, 0x5534, 0x3025, 0x6534, 0x3025 shows the values 3, 2, 4, 6, 0, 6 on `dispB` in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| progAddr | output | 8 | Address of the current instruction |
| progInstr | input | 16 | Instruction word at `progAddr` |
| dispStrobe | output | 1 | High during a display instruction |
| dispA | output | 4 | Value of source register A |
| dispB | output | 4 | Value of source register B, the value to be shown |

## Verification
Every register-register operation is run over all 256 pairs of operands. These sweeps separate XOR from OR on overlapping bits, and ADD from SUB at wrap-around and borrow. They also show whether the subtract carry-in is missing. Load and move chains put a distinct value in every register, including immediates with bit 3 set, so a wrong field slice or a wrong register address shows up as a wrong value. A self-overwriting subtract and add tests that a read sees the old value. Unused opcodes are placed between writes with nonzero operand fields, a reset is applied after nonzero loads, and a long run of no-ops crosses the address wrap.

// File: rtl/nibble_cpu_pkg.sv
package nibble_cpu_pkg;

  typedef enum logic [1:0] {
    ALU_XOR = 2'b00,
    ALU_AND = 2'b01,
    ALU_OR  = 2'b10,
    ALU_ADD = 2'b11
  } aluSel_e;

  typedef enum logic [1:0] {
    WB_IMM  = 2'b00,
    WB_ALU  = 2'b01,
    WB_REGA = 2'b10,
    WB_NONE = 2'b11
  } wbSel_e;

  // Packed so that bit 6 is subFlag and bit 0 is regWe
  typedef struct packed {
    logic    subFlag;
    aluSel_e aluSel;
    wbSel_e  wbSel;
    logic    dispEn;
    logic    regWe;
  } ctrl_t;

  localparam int OPC_W   = 4;
  localparam int INSTR_W = 16;

  localparam logic [OPC_W-1:0] OP_NOP  = 4'b0000;
  localparam logic [OPC_W-1:0] OP_LD   = 4'b0001;
  localparam logic [OPC_W-1:0] OP_MOV  = 4'b0010;
  localparam logic [OPC_W-1:0] OP_DISP = 4'b0011;
  localparam logic [OPC_W-1:0] OP_XOR  = 4'b0100;
  localparam logic [OPC_W-1:0] OP_AND  = 4'b0101;
  localparam logic [OPC_W-1:0] OP_OR   = 4'b0110;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'b0111;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'b1111;

endpackage

// File: rtl/nibble_ctrl.sv
module nibble_ctrl
  import nibble_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrlWord
);

  always_comb begin
    ctrlWord = '0;
    unique case (opcode)
      OP_LD: begin
        ctrlWord.wbSel = WB_IMM;
        ctrlWord.regWe = 1'b1;
      end
      OP_MOV: begin
        ctrlWord.wbSel = WB_REGA;
        ctrlWord.regWe = 1'b1;
      end
      OP_DISP: ctrlWord.dispEn = 1'b1;
      OP_XOR, OP_AND, OP_OR, OP_ADD: begin
        ctrlWord.aluSel = aluSel_e'(opcode[1:0]);
        ctrlWord.wbSel  = WB_ALU;
        ctrlWord.regWe  = 1'b1;
      end
      OP_SUB: begin
        ctrlWord.subFlag = 1'b1;
        ctrlWord.aluSel  = ALU_ADD;
        ctrlWord.wbSel   = WB_ALU;
        ctrlWord.regWe   = 1'b1;
      end
      default: ctrlWord = '0;  // no-op and the unused opcodes
    endcase
  end

endmodule

// File: rtl/nibble_regfile.sv
module nibble_regfile #(
  parameter int DATA_W  = 4,
  parameter int REG_CNT = 8,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);

  logic [REG_CNT-1:0] wrHot;
  logic [DATA_W-1:0]  regs [REG_CNT];

  // One-hot decode of the destination address
  assign wrHot = wrEn ? (REG_CNT'(1) << wrAddr) : '0;

  for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs[i] <= '0;
      else if (wrHot[i]) regs[i] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

endmodule

// File: rtl/nibble_datapath.sv
module nibble_datapath
  import nibble_cpu_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int REG_CNT = 8,
  parameter int PC_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrlWord,
  input  logic [INSTR_W-1:0] instr,
  output logic [PC_W-1:0]    pcOut,
  output logic [DATA_W-1:0]  srcA,
  output logic [DATA_W-1:0]  srcB
);

  localparam int ADDR_W = $clog2(REG_CNT);
  localparam int RD_LSB = 8;
  localparam int RA_LSB = 4;
  localparam int RB_LSB = 0;

  logic [ADDR_W-1:0] rdAddr, raAddr, rbAddr;
  logic [DATA_W-1:0] immVal, raVal, rbVal;
  logic [DATA_W-1:0] bOperand, sumVal, aluVal, wbData;
  logic              wrEn;
  logic [PC_W-1:0]   pcReg;

  assign rdAddr = instr[RD_LSB +: ADDR_W];
  assign raAddr = instr[RA_LSB +: ADDR_W];
  assign rbAddr = instr[RB_LSB +: ADDR_W];
  assign immVal = instr[DATA_W-1:0];

  nibble_regfile #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT)
  ) u_regfile (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrAddr  (rdAddr),
    .wrData  (wbData),
    .rdAddrA (raAddr),
    .rdAddrB (rbAddr),
    .rdDataA (raVal),
    .rdDataB (rbVal)
  );

  // One adder does add and subtract: A + ~B + 1 when subtracting
  assign bOperand = ctrlWord.subFlag ? ~rbVal : rbVal;
  assign sumVal   = raVal + bOperand + DATA_W'(ctrlWord.subFlag);

  always_comb begin
    unique case (ctrlWord.aluSel)
      ALU_XOR: aluVal = raVal ^ rbVal;
      ALU_AND: aluVal = raVal & rbVal;
      ALU_OR:  aluVal = raVal | rbVal;
      default: aluVal = sumVal;
    endcase
  end

  always_comb begin
    unique case (ctrlWord.wbSel)
      WB_IMM:  wbData = immVal;
      WB_ALU:  wbData = aluVal;
      WB_REGA: wbData = raVal;
      default: wbData = '0;
    endcase
  end

  assign wrEn = ctrlWord.regWe && (ctrlWord.wbSel != WB_NONE);

  always_ff @(posedge clk) begin
    if (rst) pcReg <= '0;
    else     pcReg <= pcReg + PC_W'(1);
  end

  assign pcOut = pcReg;
  assign srcA  = raVal;
  assign srcB  = rbVal;

endmodule

// File: rtl/nibble_cpu.sv
module nibble_cpu
  import nibble_cpu_pkg::*;
#(
  parameter int DATA_W  = 4,
  parameter int REG_CNT = 8,
  parameter int PC_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    progAddr,
  input  logic [INSTR_W-1:0] progInstr,
  output logic               dispStrobe,
  output logic [DATA_W-1:0]  dispA,
  output logic [DATA_W-1:0]  dispB
);

  ctrl_t ctrlWord;

  nibble_ctrl u_ctrl (
    .opcode   (progInstr[INSTR_W-1 -: OPC_W]),
    .ctrlWord (ctrlWord)
  );

  nibble_datapath #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT),
    .PC_W    (PC_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrlWord (ctrlWord),
    .instr    (progInstr),
    .pcOut    (progAddr),
    .srcA     (dispA),
    .srcB     (dispB)
  );

  assign dispStrobe = ctrlWord.dispEn;

endmodule

// File: rtl/nibble_cpu_checker.sv
module nibble_cpu_checker
  import nibble_cpu_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    progAddr,
  input logic [INSTR_W-1:0] progInstr,
  input logic               dispStrobe,
  input ctrl_t              ctrlWord
);

  logic seenRst = 1'b0;
  logic [OPC_W-1:0] opc;

  always_ff @(posedge clk) if (rst) seenRst <= 1'b1;

  assign opc = progInstr[INSTR_W-1 -: OPC_W];

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst || !seenRst)
    1'b1 |=> progAddr == PC_W'($past(progAddr) + PC_W'(1)));

  assert_pc_reset_R10: assert property (@(posedge clk) disable iff (!seenRst)
    rst |=> progAddr == '0);

  assert_disp_only_op_R7: assert property (@(posedge clk) disable iff (rst || !seenRst)
    dispStrobe |-> (opc == OP_DISP) && !ctrlWord.regWe);

  assert_unused_quiet_R8: assert property (@(posedge clk) disable iff (rst || !seenRst)
    (opc == OP_NOP || (opc >= 4'd8 && opc <= 4'd14)) |-> !dispStrobe && !ctrlWord.regWe);

  assert_sub_uses_adder_R6: assert property (@(posedge clk) disable iff (rst || !seenRst)
    ctrlWord.subFlag |-> ctrlWord.aluSel == ALU_ADD && ctrlWord.wbSel == WB_ALU);

endmodule

bind nibble_cpu nibble_cpu_checker #(.PC_W(PC_W)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .progAddr   (progAddr),
  .progInstr  (progInstr),
  .dispStrobe (dispStrobe),
  .ctrlWord   (ctrlWord)
);

// File: tb/nibble_cpu_bench.sv
`timescale 1ns/1ps
module nibble_cpu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  progAddr;
  logic [15:0] progInstr;
  logic        dispStrobe;
  logic [3:0]  dispA, dispB;

  logic [15:0] progMem [256];
  int          mreg [8];
  int          shownVals [256];
  int          shownCnt;
  int          passCnt = 0;
  int          failCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign progInstr = progMem[progAddr];

  nibble_cpu u_nibble_cpu (
    .clk        (clk),
    .rst        (rst),
    .progAddr   (progAddr),
    .progInstr  (progInstr),
    .dispStrobe (dispStrobe),
    .dispA      (dispA),
    .dispB      (dispB)
  );

  function automatic logic [15:0] enc(int op, int rd, int ra, int rb);
    return {4'(op), 1'b0, 3'(rd), 1'b0, 3'(ra), 4'(rb)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) progMem[i] = 16'h0000;
  endtask

  // Reset, then run with a per-instruction reference model
  task automatic runProgram(int cycles, string req);
    int mpc, op, rd, ra, rb, imm;
    logic [15:0] ins;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) mreg[i] = 0;  // R10 reset state
    mpc = 0;
    shownCnt = 0;
    for (int c = 0; c < cycles; c++) begin
      ins = progMem[mpc];
      op = int'(ins[15:12]); rd = int'(ins[10:8]);
      ra = int'(ins[6:4]);   rb = int'(ins[2:0]); imm = int'(ins[3:0]);
      chk(int'(progAddr) == mpc, "R9", int'(progAddr), mpc);
      chk(dispStrobe == (op == 3), "R7 strobe", int'(dispStrobe), int'(op == 3));
      if (op == 3) begin
        chk(int'(dispA) == mreg[ra], {req, " R7 dispA"}, int'(dispA), mreg[ra]);
        chk(int'(dispB) == mreg[rb], {req, " R7 dispB"}, int'(dispB), mreg[rb]);
        shownVals[shownCnt] = int'(dispB);
        shownCnt++;
      end
      case (op)
        1:  mreg[rd] = imm;
        2:  mreg[rd] = mreg[ra];
        4:  mreg[rd] = mreg[ra] ^ mreg[rb];
        5:  mreg[rd] = mreg[ra] & mreg[rb];
        6:  mreg[rd] = mreg[ra] | mreg[rb];
        7:  mreg[rd] = (mreg[ra] + mreg[rb]) % 16;
        15: mreg[rd] = (mreg[ra] - mreg[rb] + 16) % 16;
        default: ;
      endcase
      mpc = (mpc + 1) % 256;
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    int pos;
    int sample [16] = '{16'h1000, 16'h1101, 16'h1203, 16'h1303, 16'h3023, 16'h2420,
                        16'hF441, 16'h3024, 16'h7331, 16'h3023, 16'h4534, 16'h3025,
                        16'h5534, 16'h3025, 16'h6534, 16'h3025};
    int expShow [6] = '{3, 2, 4, 6, 0, 6};

    // R12 sample program, also R11 (SUB R4,R4,R1)
    clearMem();
    for (int i = 0; i < 16; i++) progMem[i] = 16'(sample[i]);
    runProgram(16, "R12");
    chk(shownCnt == 6, "R12 count", shownCnt, 6);
    for (int i = 0; i < 6; i++)
      chk(shownVals[i] == expShow[i], "R12 value", shownVals[i], expShow[i]);

    // R4 R5 R6 exhaustive operand sweep; opcodes 4,5,6,7,15
    for (int k = 0; k < 5; k++) begin
      int op = (k == 4) ? 15 : 4 + k;
      for (int a = 0; a < 16; a++) begin
        clearMem();
        pos = 0;
        progMem[pos++] = enc(1, 1, 0, a);
        for (int b = 0; b < 16; b++) begin
          progMem[pos++] = enc(1, 2, 0, b);
          progMem[pos++] = enc(op, 3, 1, 2);
          progMem[pos++] = enc(3, 0, 1, 3);
        end
        runProgram(pos, (op == 15) ? "R6" : (op == 7) ? "R5" : "R4");
        for (int b = 0; b < 16; b++) begin
          int exp;
          case (op)
            4: exp = a ^ b;
            5: exp = a & b;
            6: exp = a | b;
            7: exp = (a + b) % 16;
            default: exp = (a - b + 16) % 16;
          endcase
          chk(shownVals[b] == exp, "R4/R5/R6 result", shownVals[b], exp);
        end
      end
    end

    // R1 R2 R3 R11: loads with bit 3 set, move chain, self-overwrite
    clearMem();
    pos = 0;
    for (int r = 0; r < 8; r++) progMem[pos++] = enc(1, r, 0, 15 - r);
    progMem[pos++] = enc(2, 0, 7, 0);
    progMem[pos++] = enc(2, 7, 1, 0);
    progMem[pos++] = enc(7, 2, 2, 2);
    progMem[pos++] = enc(15, 3, 3, 4);
    for (int r = 0; r < 8; r++) progMem[pos++] = enc(3, 0, 7 - r, r);
    runProgram(pos, "R1 R2 R3 R11");
    chk(shownVals[0] == 8,  "R3 move", shownVals[0], 8);
    chk(shownVals[2] == 10, "R11 self add", shownVals[2], 10);
    chk(shownVals[3] == 1,  "R11 self sub", shownVals[3], 1);
    chk(shownVals[5] == 10, "R1 imm field", shownVals[5], 10);

    // R10: registers are nonzero, reset must clear them
    clearMem();
    for (int r = 0; r < 8; r++) progMem[r] = enc(3, r, r, r);
    runProgram(8, "R10");
    for (int r = 0; r < 8; r++) chk(shownVals[r] == 0, "R10 cleared", shownVals[r], 0);

    // R8: unused opcodes and no-op with nonzero fields
    clearMem();
    pos = 0;
    for (int r = 0; r < 8; r++) progMem[pos++] = enc(1, r, 0, r + 5);
    for (int op = 8; op <= 14; op++) progMem[pos++] = enc(op, op - 8, 7, 6);
    progMem[pos++] = enc(0, 3, 2, 1);
    for (int r = 0; r < 8; r++) progMem[pos++] = enc(3, 0, r, r);
    runProgram(pos, "R8");
    for (int r = 0; r < 8; r++)
      chk(shownVals[r] == r + 5, "R8 unchanged", shownVals[r], r + 5);

    // R9: run across the address wrap
    clearMem();
    progMem[255] = enc(3, 0, 0, 0);
    runProgram(300, "R9");
    chk(shownCnt == 1, "R9 wrap display", shownCnt, 1);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule